// File: doc/BRIEF.md
# Six-Lane Lossless Differential Pixel Encoder

This block turns a raster stream of 12-bit pixels into variable-length codes and takes six pixels on every clock. Each pixel is predicted from its left neighbour. Only the signed difference between pixel and prediction is coded, never the raw intensity. For each difference the block finds its magnitude class: the number of significant bits in its absolute value. It emits a short prefix from a fixed table that names the class, followed by that many difference bits.

Each lane delivers a right-aligned code word and a length field to a downstream bit packer. The block works only on the live stream and never reads stored frame data. The predictor chains across the six lanes of a beat and from the last lane of one beat into the first lane of the next. A start-of-line flag restarts the chain from mid-scale.

The pipeline has three stages that always move together. An accepted beat appears at the outputs after three advancing clock edges. A stall input holds every stage in place.

Top module: `dpcm_lane_encoder`

## Requirements
- R1: Lane 0 is `in_pix[11:0]` and lane k is `in_pix[12k+11:12k]`. Lane k>0 is predicted from lane k-1 of the same beat. Lane 0 is predicted from lane 5 of the last accepted beat, or from 2048 when `in_sol` is high.
- R2: The difference is pixel minus prediction, taken modulo 2^16. Its class is the bit length of its absolute value, which gives 0 for a zero difference and at most 12.
- R3: The prefix for class c is a fixed table. For c from 0 to 5 it is 3 bits holding c in binary. For c of 6 or more it is c-2 bits long and consists of c-3 ones followed by a single zero.
- R4: The difference field is c bits long. A non-negative difference sends its low c bits. A negative difference sends the low c bits of the one's complement of its absolute value. Class 0 sends no field.
- R5: Lane k of `out_code` is bits [24k+23:24k] and holds the prefix followed by the field, right-aligned, with all bits above them zero. Lane k of `out_len` is bits [5k+4:5k] and holds the prefix length plus c, never more than 22.
- R6: A beat accepted with `in_valid` high and `stall` low appears with `out_valid` high after exactly three clock edges that have `stall` low. Beats leave in the order they were accepted.
- R7: While `stall` is high, no stage, output or predictor memory changes, and the input beat is ignored.
- R8: A beat with `in_valid` low leaves the predictor memory unchanged. When it reaches the outputs, `out_valid` is low and every code and length bit is zero.
- R9: Under synchronous active-low reset, `out_valid` and all output fields are zero and the predictor memory is 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freezes the whole pipeline; the input beat is ignored |
| in_valid | input | 1 | The input beat carries pixels |
| in_sol | input | 1 | Lane 0 is the first pixel of a line |
| in_pix | input | 72 | Six 12-bit pixels, lane 0 in the low bits |
| out_valid | output | 1 | Output beat is valid |
| out_code | output | 144 | Six 24-bit right-aligned code words |
| out_len | output | 30 | Six 5-bit code lengths |

## Verification
Two conditions are hard to reach from the ports. The first is a difference at the extremes of its range, ±4095, which needs a 0 and a 4095 to sit next to each other. The second is a cross-beat prediction that must survive stalls and idle beats in between. A sweep of 4096 beats gives every difference from -4095 to 4095: it places the value v, 0, 4095 and 4095-v in chained lanes, and the start-of-line restart adds one more form of v. A long random phase then mixes idle beats, stalls and beats without start-of-line. In that phase lane 0 of a beat must still be predicted from the last accepted beat, however many non-advancing cycles lie between them.

// File: rtl/dpcm_pkg.sv
// Shared constants and the fixed prefix table for the differential encoder.
// Assumes classes fit in 0..16; only 0..PIX_W are reachable at run time.
package dpcm_pkg;

    // Prefix length for a magnitude class (fixed table, R3)
    function automatic int pfx_len(input int cat);
        return (cat < 6) ? 3 : cat - 2;
    endfunction

    // Prefix bit pattern for a magnitude class (fixed table, R3)
    function automatic int pfx_val(input int cat);
        return (cat < 6) ? cat : ((1 << (cat - 2)) - 2);
    endfunction

endpackage

// File: rtl/dpcm_predict.sv
// Stage 1: forms each lane's prediction and the modulo 2^DIFF_W difference.
// Lane k>0 uses lane k-1 of the same beat. Lane 0 uses the stored last pixel
// of the previous accepted beat, or mid-scale at line start.
// Assumes adv low means the whole pipeline holds.
module dpcm_predict #(
    parameter int LANES  = 6,
    parameter int PIX_W  = 12,
    parameter int DIFF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    in_valid,
    input  logic                    in_sol,
    input  logic [LANES*PIX_W-1:0]  in_pix,
    output logic                    s1_valid,
    output logic [LANES*DIFF_W-1:0] s1_diff
);
    localparam logic [PIX_W-1:0] MID = {1'b1, {(PIX_W-1){1'b0}}};

    logic [PIX_W-1:0]        last_pix;
    logic [LANES*DIFF_W-1:0] diff_c;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [PIX_W-1:0] pred;
        if (k == 0) begin : g_first
            // Lane 0 prediction: mid-scale at line start, else carried pixel
            always_comb pred = in_sol ? MID : last_pix;
        end else begin : g_rest
            // Lane k prediction: left neighbour inside the beat
            always_comb pred = in_pix[(k-1)*PIX_W +: PIX_W];
        end
        // Difference modulo 2^DIFF_W
        always_comb diff_c[k*DIFF_W +: DIFF_W] =
            DIFF_W'(in_pix[k*PIX_W +: PIX_W]) - DIFF_W'(pred);
    end

    // Stage register and cross-beat predictor memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_diff  <= '0;
            last_pix <= MID;
        end else if (adv) begin
            s1_valid <= in_valid;
            s1_diff  <= in_valid ? diff_c : '0;
            if (in_valid) last_pix <= in_pix[(LANES-1)*PIX_W +: PIX_W];
        end
    end
endmodule

// File: rtl/dpcm_category.sv
// Stage 2: magnitude class (bit length of |difference|) for every lane.
// Assumes differences are two's complement DIFF_W-bit values.
module dpcm_category #(
    parameter int LANES  = 6,
    parameter int DIFF_W = 16,
    parameter int CAT_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    s1_valid,
    input  logic [LANES*DIFF_W-1:0] s1_diff,
    output logic                    s2_valid,
    output logic [LANES*DIFF_W-1:0] s2_diff,
    output logic [LANES*CAT_W-1:0]  s2_cat
);
    logic [LANES*CAT_W-1:0] cat_c;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [DIFF_W-1:0] d;
        logic [DIFF_W-1:0] mag;
        // Absolute value and its bit length
        always_comb begin
            d   = s1_diff[k*DIFF_W +: DIFF_W];
            mag = d[DIFF_W-1] ? (DIFF_W'(0) - d) : d;
            cat_c[k*CAT_W +: CAT_W] = '0;
            for (int b = 0; b < DIFF_W; b++)
                if (mag[b]) cat_c[k*CAT_W +: CAT_W] = CAT_W'(b + 1);
        end
    end

    // Stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_diff  <= '0;
            s2_cat   <= '0;
        end else if (adv) begin
            s2_valid <= s1_valid;
            s2_diff  <= s1_diff;
            s2_cat   <= cat_c;
        end
    end
endmodule

// File: rtl/dpcm_codeform.sv
// Stage 3: prefix lookup from the fixed table, field truncation and
// assembly of right-aligned lane code words with lengths.
// Assumes classes never exceed PIX_W.
module dpcm_codeform #(
    parameter int LANES  = 6,
    parameter int PIX_W  = 12,
    parameter int DIFF_W = 16,
    parameter int CAT_W  = 5,
    parameter int CODE_W = 24,
    parameter int LEN_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    s2_valid,
    input  logic [LANES*DIFF_W-1:0] s2_diff,
    input  logic [LANES*CAT_W-1:0]  s2_cat,
    output logic                    out_valid,
    output logic [LANES*CODE_W-1:0] out_code,
    output logic [LANES*LEN_W-1:0]  out_len
);
    import dpcm_pkg::*;

    logic [LANES*CODE_W-1:0] code_c;
    logic [LANES*LEN_W-1:0]  len_c;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [CAT_W-1:0]  cat;
        logic [DIFF_W-1:0] d;
        logic [DIFF_W-1:0] adj;
        logic [CODE_W-1:0] pval;
        logic [CODE_W-1:0] mask;
        logic [LEN_W-1:0]  plen;
        // Fixed prefix table selected by class
        always_comb begin
            cat  = s2_cat[k*CAT_W +: CAT_W];
            plen = '0;
            pval = '0;
            for (int c = 0; c <= PIX_W; c++)
                if (cat == CAT_W'(c)) begin
                    plen = LEN_W'(pfx_len(c));
                    pval = CODE_W'(pfx_val(c));
                end
        end
        // Field: value itself, or one's complement of |d| (= d-1) if negative
        always_comb begin
            d    = s2_diff[k*DIFF_W +: DIFF_W];
            adj  = d[DIFF_W-1] ? (d - DIFF_W'(1)) : d;
            mask = (CODE_W'(1) << cat) - CODE_W'(1);
            code_c[k*CODE_W +: CODE_W] = (pval << cat) | (CODE_W'(adj) & mask);
            len_c[k*LEN_W +: LEN_W]    = plen + LEN_W'(cat);
        end
    end

    // Output register; idle beats leave all fields zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
            out_len   <= '0;
        end else if (adv) begin
            out_valid <= s2_valid;
            out_code  <= s2_valid ? code_c : '0;
            out_len   <= s2_valid ? len_c : '0;
        end
    end
endmodule

// File: rtl/dpcm_lane_encoder.sv
// Top: six-lane lossless differential encoder, three lock-step stages.
// Assumes the producer holds a stalled beat and re-presents it later.
module dpcm_lane_encoder #(
    parameter int LANES  = 6,
    parameter int PIX_W  = 12,
    parameter int DIFF_W = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     stall,
    input  logic                                     in_valid,
    input  logic                                     in_sol,
    input  logic [LANES*PIX_W-1:0]                   in_pix,
    output logic                                     out_valid,
    output logic [LANES*2*PIX_W-1:0]                 out_code,
    output logic [LANES*$clog2(2*PIX_W+1)-1:0]       out_len
);
    localparam int CODE_W = 2 * PIX_W;
    localparam int LEN_W  = $clog2(CODE_W + 1);
    localparam int CAT_W  = $clog2(DIFF_W + 1);

    logic                    adv;
    logic                    s1_valid, s2_valid;
    logic [LANES*DIFF_W-1:0] s1_diff, s2_diff;
    logic [LANES*CAT_W-1:0]  s2_cat;

    // Single advance enable shared by every stage
    always_comb adv = ~stall;

    dpcm_predict #(.LANES(LANES), .PIX_W(PIX_W), .DIFF_W(DIFF_W)) u_pred (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
        .in_sol(in_sol), .in_pix(in_pix), .s1_valid(s1_valid), .s1_diff(s1_diff));

    dpcm_category #(.LANES(LANES), .DIFF_W(DIFF_W), .CAT_W(CAT_W)) u_cat (
        .clk(clk), .rst_n(rst_n), .adv(adv), .s1_valid(s1_valid),
        .s1_diff(s1_diff), .s2_valid(s2_valid), .s2_diff(s2_diff), .s2_cat(s2_cat));

    dpcm_codeform #(.LANES(LANES), .PIX_W(PIX_W), .DIFF_W(DIFF_W), .CAT_W(CAT_W),
                    .CODE_W(CODE_W), .LEN_W(LEN_W)) u_code (
        .clk(clk), .rst_n(rst_n), .adv(adv), .s2_valid(s2_valid),
        .s2_diff(s2_diff), .s2_cat(s2_cat), .out_valid(out_valid),
        .out_code(out_code), .out_len(out_len));
endmodule

// File: rtl/dpcm_lane_encoder_chk.sv
// Checker bound to the encoder top: port-level timing and format properties.
module dpcm_lane_encoder_chk #(
    parameter int LANES = 6,
    parameter int PIX_W = 12
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               stall,
    input logic                               in_valid,
    input logic                               out_valid,
    input logic [LANES*2*PIX_W-1:0]           out_code,
    input logic [LANES*$clog2(2*PIX_W+1)-1:0] out_len
);
    localparam int CODE_W  = 2 * PIX_W;
    localparam int LEN_W   = $clog2(CODE_W + 1);
    localparam int LEN_MAX = 2 * PIX_W - 2;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // R5: length never exceeds longest prefix plus longest field
        a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_len[k*LEN_W +: LEN_W] <= LEN_W'(LEN_MAX)));
        // R5: nothing set above the code length
        a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ((out_code[k*CODE_W +: CODE_W] >> out_len[k*LEN_W +: LEN_W]) == '0));
        // R3: every code carries at least a 3-bit prefix
        a_r3_min_prefix: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_len[k*LEN_W +: LEN_W] >= LEN_W'(3)));
    end

    // R7: stall freezes the outputs
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(out_valid) && $stable(out_code) && $stable(out_len)));

    // R6: an accepted beat emerges after three advancing edges
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall) ##1 !stall ##1 !stall |=> out_valid);

    // R8: idle output beats carry zero fields
    a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_code == '0 && out_len == '0));
endmodule

bind dpcm_lane_encoder dpcm_lane_encoder_chk #(.LANES(LANES), .PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid),
    .out_valid(out_valid), .out_code(out_code), .out_len(out_len));

// File: tb/dpcm_lane_encoder_test.sv
`timescale 1ns/1ps
module dpcm_lane_encoder_test;
    logic         clk = 1'b0;
    logic         rst_n, stall, in_valid, in_sol;
    logic [71:0]  in_pix;
    logic         out_valid;
    logic [143:0] out_code;
    logic [29:0]  out_len;

    always #2 clk = ~clk;

    dpcm_lane_encoder uut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid),
        .in_sol(in_sol), .in_pix(in_pix), .out_valid(out_valid),
        .out_code(out_code), .out_len(out_len));

    typedef struct { logic [143:0] code; logic [29:0] len; } beat_t;
    beat_t        expq[$];
    int           checks = 0, errors = 0;
    int           mprev  = 2048;
    bit           last_stall = 1'b0;
    logic         h_valid;
    logic [143:0] h_code;
    logic [29:0]  h_len;

    // Record one check
    task automatic chk(input bit ok, input string req, input logic [143:0] act,
                       input logic [143:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference encoding of one lane from the requirements
    task automatic ref_lane(input int x, input int pred, output logic [23:0] code,
                            output int len);
        int d, a, cat, pl, pv, f;
        d = x - pred;
        a = (d < 0) ? -d : d;
        cat = 0;
        while ((a >> cat) != 0) cat++;
        pl = (cat < 6) ? 3 : cat - 2;
        pv = (cat < 6) ? cat : ((1 << (cat - 2)) - 2);
        f  = (d >= 0) ? d : ~a;
        f  = f & ((1 << cat) - 1);
        code = 24'((pv << cat) | f);
        len  = pl + cat;
    endtask

    function automatic logic [71:0] pack6(input int p0, p1, p2, p3, p4, p5);
        return {12'(p5), 12'(p4), 12'(p3), 12'(p2), 12'(p1), 12'(p0)};
    endfunction

    // One cycle: observe after the last edge, then drive the next beat
    task automatic cycle(input bit v, input bit sol, input bit st, input logic [71:0] pix);
        beat_t e;
        @(negedge clk);
        if (last_stall) begin
            // R7: outputs unchanged across a stalled edge
            chk(out_valid == h_valid && out_code == h_code && out_len == h_len,
                "R7 stall hold", {out_len, out_code}, {h_len, h_code});
        end else if (out_valid) begin
            if (expq.size() == 0) chk(1'b0, "R6 unexpected valid beat", 144'(out_valid), 144'(0));
            else begin
                e = expq.pop_front();
                // R1 R2 R3 R4 R5: lane codes and lengths
                chk(out_code == e.code, "R1/R2/R3/R4/R5 code", out_code, e.code);
                chk(out_len == e.len, "R5 length", 144'(out_len), 144'(e.len));
            end
        end else begin
            chk(out_code == '0 && out_len == '0, "R8 idle zero", {out_len, out_code}, 144'(0));
        end
        h_valid = out_valid; h_code = out_code; h_len = out_len;
        stall = st; in_valid = v; in_sol = sol; in_pix = pix;
        if (v && !st) begin
            int p;
            logic [23:0] c;
            int l;
            p = sol ? 2048 : mprev;
            for (int k = 0; k < 6; k++) begin
                ref_lane(int'(pix[k*12 +: 12]), p, c, l);
                e.code[k*24 +: 24] = c;
                e.len[k*5 +: 5]    = 5'(l);
                p = int'(pix[k*12 +: 12]);
            end
            mprev = p;
            expq.push_back(e);
        end
        last_stall = st;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; stall = 1'b0; in_valid = 1'b1; in_sol = 1'b0;
        in_pix = pack6(1, 4095, 7, 0, 99, 3000);
        repeat (4) @(negedge clk);
        // R9: reset clears outputs even with a valid input present
        chk(out_valid == 1'b0, "R9 reset valid", 144'(out_valid), 144'(0));
        chk(out_code == '0 && out_len == '0, "R9 reset fields", {out_len, out_code}, 144'(0));
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        h_valid = out_valid; h_code = out_code; h_len = out_len;

        // R9/R1: first beat without line start predicts from 2048
        cycle(1, 0, 0, pack6(2048, 2049, 2047, 2050, 4095, 0));
        cycle(0, 0, 0, '0);
        chk(out_valid == 1'b0, "R6 no output after one edge", 144'(out_valid), 144'(0));
        cycle(0, 0, 0, '0);
        chk(out_valid == 1'b0, "R6 no output after two edges", 144'(out_valid), 144'(0));
        cycle(0, 0, 0, '0);
        chk(out_valid == 1'b1, "R6 output after three edges", 144'(out_valid), 144'(1));

        // R2/R4: sweep covering every difference from -4095 to 4095
        for (int v = 0; v < 4096; v++)
            cycle(1, 1, 0, pack6(v, 0, v, 4095, 4095 - v, v));

        // R1/R7/R8: random idles, stalls and cross-beat chaining
        for (int n = 0; n < 4000; n++)
            cycle(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 4) == 0,
                  pack6($urandom % 4096, $urandom % 4096, $urandom % 4096,
                        $urandom % 4096, $urandom % 4096, $urandom % 4096));

        // R1: stall and idle gaps between two chained beats
        cycle(1, 0, 0, pack6(100, 200, 300, 400, 500, 600));
        cycle(1, 0, 1, pack6(4095, 4095, 4095, 4095, 4095, 4095));
        cycle(0, 0, 0, pack6(1, 1, 1, 1, 1, 1));
        cycle(1, 0, 0, pack6(611, 590, 600, 600, 0, 4095));

        for (int n = 0; n < 6; n++) cycle(0, 0, 0, '0);
        chk(expq.size() == 0, "R6 all beats delivered", 144'(expq.size()), 144'(0));
        summary();
        $finish;
    end
endmodule